// File: doc/BRIEF.md
# Lane-Partitioned Fixed-Point Vector ALU

This block is one wide integer datapath that can be split at run time into independent lanes. Each cycle it takes two operand vectors. It performs the same element-wise operation in every lane: add, subtract, or the low half of a multiply. The lane size is chosen per operation: 8, 16 or 32 bits, or a 40-bit extended mode for sums that need headroom.

Each operation also carries two flags. One selects signed or unsigned interpretation. The other selects whether an out-of-range result wraps or clamps. The result, a mask marking which lanes went out of range, and a valid flag all appear one clock after the operation is presented.

Top module: `simd_fx_alu`

## Requirements
- R1: `lane_sz` selects the lane width: 0 gives 8-bit lanes (32 lanes), 1 gives 16-bit lanes (16 lanes), 2 gives 32-bit lanes (8 lanes) and 3 gives 40-bit lanes (6 lanes, at bit offsets 0, 40, 80, 120, 160 and 200). Lane i occupies bits [i*W +: W]. No carry or borrow crosses from one lane into the next.
- R2: `op` selects the operation: 2'b00 is a + b, 2'b01 is a - b, and 2'b10 or 2'b11 is a * b, keeping the low W bits of the product.
- R3: With `sat_en` = 0, each lane's result is the low W bits of the exact mathematical result.
- R4: With `sat_en` = 1 and `is_signed` = 1, a result above the lane range becomes 2^(W-1)-1. A result below the lane range becomes -2^(W-1).
- R5: With `sat_en` = 1 and `is_signed` = 0, a result above the lane range becomes all ones. A result below zero becomes zero.
- R6: `is_signed` selects two's-complement or unsigned interpretation of the operands. This affects both the product and the range test.
- R7: In 40-bit mode, result bits [255:240] are zero.
- R8: `ovf_mask` has one bit per 8-bit slice. The bit of the lowest slice of each lane (slice i*W/8) is set when that lane's exact result fell outside the lane range, with or without saturation. All other bits are zero.
- R9: `out_valid` equals `in_valid` of the previous clock. `result` and `ovf_mask` are registered and belong to the operation presented on that previous clock.
- R10: On a clock where `in_valid` is low, `result` and `ovf_mask` keep their previous values.
- R11: During and right after reset, `out_valid`, `result` and `ovf_mask` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| opa | input | 256 | First operand vector |
| opb | input | 256 | Second operand vector |
| op | input | 2 | Operation code |
| lane_sz | input | 2 | Lane width select |
| is_signed | input | 1 | Signed interpretation |
| sat_en | input | 1 | Saturate instead of wrap |
| out_valid | output | 1 | Result valid |
| result | output | 256 | Result vector |
| ovf_mask | output | 32 | Per-slice overflow flags |

## Verification
The bench builds the block with its default 256-bit width. At this width all four lane sizes are present, and the 40-bit mode leaves a 16-bit unused tail at the top of the vector and two unused mask slices. These parameter values put the unused-tail case, the 40-bit lane offsets that do not align to 32 bits, and carries at every lane boundary within reach of both directed and random operations. A behavioural reference model computes each lane with wide integers and is compared on every clock, covering wrap, both saturation directions and multiply in each signedness.

// File: rtl/simd_fx_alu.sv
module simd_fx_alu #(
  parameter int DATA_W = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [1:0]        op,
  input  logic [1:0]        lane_sz,
  input  logic              is_signed,
  input  logic              sat_en,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W/8-1:0] ovf_mask
);
  localparam int NSL = DATA_W / 8;
  localparam int EW  = 82;

  function automatic logic [40:0] lane_calc(input logic [39:0] a, input logic [39:0] b,
                                            input int w, input logic [1:0] opc,
                                            input logic sg, input logic st);
    logic [EW-1:0] am, bm, one_w, one_h;
    logic signed [EW-1:0] x, y, f, hi, lo;
    logic ov;
    one_w = 82'd1 << w;
    one_h = 82'd1 << (w - 1);
    am = {42'd0, a} & (one_w - 82'd1);
    bm = {42'd0, b} & (one_w - 82'd1);
    x = (sg && a[w-1]) ? $signed(am) - $signed(one_w) : $signed(am);
    y = (sg && b[w-1]) ? $signed(bm) - $signed(one_w) : $signed(bm);
    hi = sg ? $signed(one_h - 82'd1) : $signed(one_w - 82'd1);
    lo = sg ? -$signed(one_h) : '0;
    case (opc)
      2'b00:   f = x + y;
      2'b01:   f = x - y;
      default: f = x * y;
    endcase
    ov = (f > hi) || (f < lo);
    if (st && ov) f = (f > hi) ? hi : lo;
    return {ov, f[39:0]};
  endfunction

  function automatic logic [NSL-1:0] lead_mask(input logic [1:0] ls);
    int lw;
    logic [NSL-1:0] m;
    lw = (ls == 2'd0) ? 8 : (ls == 2'd1) ? 16 : (ls == 2'd2) ? 32 : 40;
    m = '0;
    for (int s = 0; s < NSL; s++)
      if ((s % (lw / 8)) == 0 && (s / (lw / 8)) < (DATA_W / lw)) m[s] = 1'b1;
    return m;
  endfunction

  logic [4*DATA_W-1:0] res_all;
  logic [4*NSL-1:0]    ovf_all;

  for (genvar g = 0; g < 4; g++) begin : g_width
    localparam int LW = (g == 0) ? 8 : (g == 1) ? 16 : (g == 2) ? 32 : 40;
    localparam int NL = DATA_W / LW;
    localparam int LS = LW / 8;
    logic [NL-1:0] lov;

    for (genvar i = 0; i < NL; i++) begin : g_lane
      logic [40:0] o;
      assign o = lane_calc(40'(opa[i*LW +: LW]), 40'(opb[i*LW +: LW]),
                           LW, op, is_signed, sat_en);
      assign res_all[g*DATA_W + i*LW +: LW] = o[LW-1:0];
      assign lov[i] = o[40];
    end

    if (NL * LW < DATA_W) begin : g_tail
      assign res_all[g*DATA_W + NL*LW +: DATA_W - NL*LW] = '0;
    end

    for (genvar s = 0; s < NSL; s++) begin : g_slice
      if ((s % LS) == 0 && (s / LS) < NL) begin : g_lead
        assign ovf_all[g*NSL + s] = lov[s / LS];
      end else begin : g_rest
        assign ovf_all[g*NSL + s] = 1'b0;
      end
    end
  end

  logic [1:0] lsz_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf_mask  <= '0;
      lsz_q     <= 2'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= res_all[lane_sz*DATA_W +: DATA_W];
        ovf_mask <= ovf_all[lane_sz*NSL +: NSL];
        lsz_q    <= lane_sz;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R9
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(ovf_mask))); // R10
  AST_WIDE_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && lsz_q == 2'd3) |-> (result[DATA_W-1:240] == '0)); // R7
  AST_MASK_LEAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((ovf_mask & ~lead_mask(lsz_q)) == '0)); // R8
endmodule

// File: tb/simd_fx_alu_test.sv
module simd_fx_alu_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [255:0] opa = '0, opb = '0;
  logic [1:0] op = 2'd0, lane_sz = 2'd0;
  logic is_signed = 1'b0, sat_en = 1'b0;
  logic out_valid;
  logic [255:0] result;
  logic [31:0] ovf_mask;

  int checks = 0, failures = 0;
  logic [255:0] exp_r = '0;
  logic [31:0]  exp_m = '0;
  bit done = 0;

  always #4 clk = ~clk;

  simd_fx_alu uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
                   .op(op), .lane_sz(lane_sz), .is_signed(is_signed), .sat_en(sat_en),
                   .out_valid(out_valid), .result(result), .ovf_mask(ovf_mask));

  function automatic void ref_calc(input logic [255:0] a, input logic [255:0] b,
                                   input logic [1:0] opc, input logic [1:0] ls,
                                   input logic sg, input logic st,
                                   output logic [255:0] r, output logic [31:0] m);
    int w, n;
    logic signed [127:0] x, y, f, hi, lo;
    w = (ls == 0) ? 8 : (ls == 1) ? 16 : (ls == 2) ? 32 : 40;
    n = 256 / w;
    r = '0;
    m = '0;
    for (int i = 0; i < n; i++) begin
      x = 0;
      y = 0;
      for (int k = 0; k < w; k++) begin
        x[k] = a[i*w + k];
        y[k] = b[i*w + k];
      end
      if (sg && x[w-1]) x = x - (128'sd1 <<< w);
      if (sg && y[w-1]) y = y - (128'sd1 <<< w);
      if (opc == 2'b00) f = x + y;
      else if (opc == 2'b01) f = x - y;
      else f = x * y;
      hi = sg ? (128'sd1 <<< (w - 1)) - 1 : (128'sd1 <<< w) - 1;
      lo = sg ? -(128'sd1 <<< (w - 1)) : 128'sd0;
      if (f > hi || f < lo) begin
        m[i*w/8] = 1'b1;
        if (st) f = (f > hi) ? hi : lo;
      end
      for (int k = 0; k < w; k++) r[i*w + k] = f[k];
    end
  endfunction

  task automatic chk(input string tag, input logic [255:0] gr, input logic [255:0] er,
                     input logic [31:0] gm, input logic [31:0] em);
    checks++;
    if (gr !== er || gm !== em) begin
      failures++;
      $display("FAIL %s result=%h mask=%h expected result=%h mask=%h", tag, gr, gm, er, em);
    end
  endtask

  task automatic run(input logic [255:0] a, input logic [255:0] b, input logic [1:0] opc,
                     input logic [1:0] ls, input logic sg, input logic st, input logic v,
                     input string tag);
    @(negedge clk);
    opa = a; opb = b; op = opc; lane_sz = ls; is_signed = sg; sat_en = st; in_valid = v;
    if (v) ref_calc(a, b, opc, ls, sg, st, exp_r, exp_m);
    @(posedge clk);
    #1;
    checks++;
    if (out_valid !== v) begin
      failures++;
      $display("FAIL R9 out_valid=%b expected %b", out_valid, v);
    end
    chk(tag, result, exp_r, ovf_mask, exp_m);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R11 out_valid=%b expected 0", out_valid);
    end
    chk("R11", result, '0, ovf_mask, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R11", result, '0, ovf_mask, '0);

    run({32{8'hFF}}, {32{8'h01}}, 2'b00, 2'd0, 1'b0, 1'b0, 1'b1, "R3");
    chk("R8", result, '0, ovf_mask, 32'hFFFF_FFFF);
    run({32{8'hFF}}, {32{8'h01}}, 2'b00, 2'd0, 1'b0, 1'b1, 1'b1, "R5");
    chk("R5", result, {32{8'hFF}}, ovf_mask, 32'hFFFF_FFFF);
    run({16{16'h7FFF}}, {16{16'h0001}}, 2'b00, 2'd1, 1'b1, 1'b1, 1'b1, "R4");
    chk("R4", result, {16{16'h7FFF}}, ovf_mask, 32'h5555_5555);
    run(256'hFFFF, 256'h1, 2'b00, 2'd1, 1'b0, 1'b0, 1'b1, "R1");
    chk("R1", result, '0, ovf_mask, 32'h1);
    run('0, {8{32'h1}}, 2'b01, 2'd2, 1'b0, 1'b1, 1'b1, "R5");
    chk("R5", result, '0, ovf_mask, 32'h1111_1111);
    run({32{8'h80}}, {32{8'h01}}, 2'b01, 2'd0, 1'b1, 1'b1, 1'b1, "R4");
    chk("R4", result, {32{8'h80}}, ovf_mask, 32'hFFFF_FFFF);
    run({8{32'h0001_0000}}, {8{32'h0001_0000}}, 2'b10, 2'd2, 1'b0, 1'b0, 1'b1, "R2");
    chk("R2", result, '0, ovf_mask, 32'h1111_1111);
    run({32{8'hFF}}, {32{8'hFF}}, 2'b11, 2'd0, 1'b1, 1'b0, 1'b1, "R6");
    chk("R6", result, {32{8'h01}}, ovf_mask, 32'h0);
    run({32{8'hFF}}, {32{8'hFF}}, 2'b10, 2'd0, 1'b0, 1'b0, 1'b1, "R6");
    chk("R6", result, {32{8'h01}}, ovf_mask, 32'hFFFF_FFFF);
    run({256{1'b1}}, {256{1'b1}}, 2'b00, 2'd3, 1'b0, 1'b0, 1'b1, "R7");
    chk("R7", {result[255:240], 240'd0}, '0, ovf_mask, 32'h0210_8421);
    run({256{1'b0}}, {256{1'b1}}, 2'b01, 2'd0, 1'b0, 1'b0, 1'b0, "R10");

    for (int t = 0; t < 600; t++) begin
      logic [255:0] ra, rb;
      logic [1:0] ro, rl;
      logic rs, rt, rv;
      for (int q = 0; q < 8; q++) begin
        ra[q*32 +: 32] = $urandom;
        rb[q*32 +: 32] = $urandom;
      end
      if (t % 7 == 0) rb = ra;
      ro = 2'($urandom_range(0, 3));
      rl = 2'($urandom_range(0, 3));
      rs = 1'($urandom_range(0, 1));
      rt = 1'($urandom_range(0, 1));
      rv = ($urandom_range(0, 9) < 8);
      run(ra, rb, ro, rl, rs, rt, rv,
          !rv ? "R10" : (rl == 2'd3) ? "R7" : !rt ? "R3" : rs ? "R4" : "R5");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule